// File: doc/BRIEF.md
# Interleaved PWM Bit Discriminator

This block recovers bits from a pulse-width-modulated stream without a local bit clock. A pulse whose high time is longer than half of its period carries a 1. A pulse whose high time is shorter carries a 0. The 50% decision point comes from the stream itself. During a whole input period, a slot counts system clocks into a reference counter. During the next period, it counts the clocks in which the input is high into a sample counter. It then compares twice the sample count against the reference. This is the digital equivalent of charging one capacitor at half the rate of the other.

Four identical slots run in step. An external sequencer advances a one-hot four-bit phase word on every rising edge of the data. Each slot reads that word rotated by its own index, so in any input period one slot is taking a reference, one is sampling, one is comparing and one is publishing and clearing. The block therefore decodes one bit per input period, and the bits appear on the four outputs in turn. Each output keeps its value until the same slot publishes again, and a one-cycle valid strobe marks each update.

Top module: `pwm_interleaved_decoder`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, every `bit_o` and every `valid_o` bit is 0.
- R2: The decoded bit is 1 when twice the sample count H is greater than the reference count P of the period before the sample period.
- R3: The decoded bit is 0 when 2·H < P, which is a duty cycle below 50%.
- R4: The decoded bit is 0 when 2·H equals P exactly.
- R5: Slot k takes its reference while `phase_i[k]` is high, samples while `phase_i[(k+1)%4]` is high, compares while `phase_i[(k+2)%4]` is high, and publishes and clears while `phase_i[(k+3)%4]` is high. A bit sampled in step n therefore appears on slot (n+3)%4, in the clock after the phase bit of step n+2 rises. Before any real sample exists, a publish delivers 0.
- R6: Each publish raises that slot's `valid_o` bit for exactly one cycle. At most one `valid_o` bit is high in any cycle.
- R7: A slot's `bit_o` changes only in a cycle in which its `valid_o` bit is high.
- R8: The reference counter saturates at MAX_PERIOD (default 64). A reference period longer than that counts as MAX_PERIOD.
- R9: The sample counter saturates at MAX_PERIOD, so a high time longer than that counts as MAX_PERIOD.
- R10: Both counters of a slot are cleared during its publish phase, so every decision uses only the counts of its own two periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din_i | input | 1 | PWM data, already synchronized to clk |
| phase_i | input | 4 | One-hot phase word from the sequencer; it advances on each data rising edge |
| bit_o | output | 4 | Decoded bit held by each slot |
| valid_o | output | 4 | One-cycle strobe on each slot update |

## Verification
The bench drives duty cycles just above, just below and exactly at 50%. A wrong comparison sense or a `>=` in place of `>` turns the exact-half case into a 1. It sends a period longer than MAX_PERIOD, both as a reference and as a high time. A counter that wraps instead of saturating would then turn 1s into 0s, and a comparison without its extra bit would do the same. It follows a long period with short ones in the same slot, so a slot that failed to clear its counters, or a wrong rotation of the phase taps, shows up as a wrong bit, a wrong slot or a wrong cycle. In every cycle the bench also confirms that each output holds its value between strobes.

// File: rtl/pwmd_pkg.sv
package pwmd_pkg;
    localparam int N_PHASE = 4;

    // role positions inside a slot's rotated phase vector
    localparam int ROLE_PRE = 0;
    localparam int ROLE_SMP = 1;
    localparam int ROLE_CMP = 2;
    localparam int ROLE_CLR = 3;

    function automatic int tap_for(input int slot, input int role);
        return (slot + role) % N_PHASE;
    endfunction
endpackage

// File: rtl/pwmd_tap_rotate.sv
module pwmd_tap_rotate
    import pwmd_pkg::*;
#(
    parameter int SLOT = 0
) (
    input  logic [N_PHASE-1:0] taps_i,
    output logic [N_PHASE-1:0] roles_o
);
    for (genvar r = 0; r < N_PHASE; r++) begin : g_role
        assign roles_o[r] = taps_i[tap_for(SLOT, r)];
    end
endmodule

// File: rtl/pwmd_slot.sv
module pwmd_slot
    import pwmd_pkg::*;
#(
    parameter int MAX_PERIOD = 64,
    localparam int CNT_W = $clog2(MAX_PERIOD + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               din_i,
    input  logic [N_PHASE-1:0] roles_i,
    output logic               bit_o,
    output logic               valid_o
);
    localparam logic [CNT_W-1:0] SAT = CNT_W'(MAX_PERIOD);

    typedef struct packed {
        logic [CNT_W-1:0] ref_cnt;
        logic [CNT_W-1:0] smp_cnt;
        logic             dec;
        logic             clr_seen;
        logic             bit_v;
        logic             valid;
    } slot_st_t;

    slot_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.clr_seen = roles_i[ROLE_CLR];

        if (roles_i[ROLE_PRE] && st_q.ref_cnt != SAT) begin
            st_d.ref_cnt = st_q.ref_cnt + 1'b1;
        end
        if (roles_i[ROLE_SMP] && din_i && st_q.smp_cnt != SAT) begin
            st_d.smp_cnt = st_q.smp_cnt + 1'b1;
        end
        if (roles_i[ROLE_CMP]) begin
            // sample at full weight against reference at half weight
            st_d.dec = ({st_q.smp_cnt, 1'b0} > {1'b0, st_q.ref_cnt});
        end
        if (roles_i[ROLE_CLR]) begin
            st_d.ref_cnt = '0;
            st_d.smp_cnt = '0;
            if (!st_q.clr_seen) begin
                st_d.bit_v = st_q.dec;
                st_d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bit_o   = st_q.bit_v;
    assign valid_o = st_q.valid;
endmodule

// File: rtl/pwm_interleaved_decoder.sv
module pwm_interleaved_decoder
    import pwmd_pkg::*;
#(
    parameter int MAX_PERIOD = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               din_i,
    input  logic [N_PHASE-1:0] phase_i,
    output logic [N_PHASE-1:0] bit_o,
    output logic [N_PHASE-1:0] valid_o
);
    for (genvar k = 0; k < N_PHASE; k++) begin : g_slot
        logic [N_PHASE-1:0] roles;

        pwmd_tap_rotate #(.SLOT(k)) u_rot (
            .taps_i  (phase_i),
            .roles_o (roles)
        );

        pwmd_slot #(.MAX_PERIOD(MAX_PERIOD)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .din_i   (din_i),
            .roles_i (roles),
            .bit_o   (bit_o[k]),
            .valid_o (valid_o[k])
        );
    end
endmodule

// File: rtl/pwmd_checker.sv
module pwmd_checker
    import pwmd_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [N_PHASE-1:0] phase_i,
    input logic [N_PHASE-1:0] bit_o,
    input logic [N_PHASE-1:0] valid_o
);
    p_valid_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(valid_o));

    for (genvar k = 0; k < N_PHASE; k++) begin : g_chk
        localparam int CLR_TAP = (k + 3) % N_PHASE;

        p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
            valid_o[k] |=> !valid_o[k]);

        p_publish_timing_r5: assert property (@(posedge clk) disable iff (!rst_n)
            valid_o[k] |-> ($past(phase_i[CLR_TAP]) && !$past(phase_i[CLR_TAP], 2)));

        p_bit_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !valid_o[k] |-> $stable(bit_o[k]));
    end
endmodule

bind pwm_interleaved_decoder pwmd_checker u_pwmd_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .phase_i (phase_i),
    .bit_o   (bit_o),
    .valid_o (valid_o)
);

// File: tb/pwm_interleaved_decoder_tb_top.sv
module pwm_interleaved_decoder_tb_top;
    localparam int MAXP = 64;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       din;
    logic [3:0] phase;
    logic [3:0] bit_o;
    logic [3:0] valid_o;

    always #4 clk = ~clk;

    pwm_interleaved_decoder #(.MAX_PERIOD(MAXP)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .din_i   (din),
        .phase_i (phase),
        .bit_o   (bit_o),
        .valid_o (valid_o)
    );

    typedef struct {
        int    step;
        int    slot;
        bit    b;
        string tag;
    } exp_t;

    exp_t  sb_q[$];
    int    n_tests = 0;
    int    n_fail  = 0;
    int    pa[64];
    int    ha[64];
    string tg[64];
    int    nstep = 0;
    int    cur_step = -1;
    int    cis = 0;
    bit    done = 0;
    logic [3:0] last_bit = '0;
    int    hold_err = 0;

    function automatic int sat(input int v);
        return (v > MAXP) ? MAXP : v;
    endfunction

    function automatic bit model_bit(input int s);
        int n, rf;
        if (s < 2) return 1'b0;
        n  = s - 2;
        rf = (n >= 1) ? sat(pa[n-1]) : 0;
        return (2 * sat(ha[n])) > rf;
    endfunction

    task automatic run_step(input int p, input int h, input string tag);
        int s;
        exp_t e;
        s = nstep;
        pa[s] = p;
        ha[s] = h;
        tg[s] = tag;
        e.step = s;
        e.slot = (s + 1) % 4;
        e.b    = model_bit(s);
        e.tag  = (s < 2) ? "R5" : tg[s-2];
        sb_q.push_back(e);
        nstep = nstep + 1;
        phase = 4'b0001 << (s % 4);
        din = (h > 0);
        cur_step = s;
        cis = 0;
        for (int i = 1; i < p; i++) begin
            @(negedge clk);
            cis = i;
            din = (i < h);
        end
        @(negedge clk);
    endtask

    // monitor: sampled 2 ns after the active edge
    always @(posedge clk) begin
        #2;
        if (rst_n === 1'b1 && !done) begin
            for (int k = 0; k < 4; k++) begin
                if (valid_o[k] !== 1'b1 && bit_o[k] !== last_bit[k]) begin
                    hold_err = hold_err + 1;
                end
                last_bit[k] = bit_o[k];
            end
            if (valid_o != 4'b0000) begin
                exp_t e;
                int   sl;
                sl = -1;
                for (int k = 0; k < 4; k++) if (valid_o[k]) sl = k;
                n_tests = n_tests + 1;
                if ($countones(valid_o) != 1) begin
                    n_fail = n_fail + 1;
                    $display("FAIL R6: valid_o=%b expected one hot", valid_o);
                end
                n_tests = n_tests + 1;
                if (sb_q.size() == 0) begin
                    n_fail = n_fail + 1;
                    $display("FAIL R5: unexpected strobe valid_o=%b expected none", valid_o);
                end else begin
                    e = sb_q.pop_front();
                    if (sl != e.slot || cur_step != e.step || cis != 0) begin
                        n_fail = n_fail + 1;
                        $display("FAIL R5: slot=%0d step=%0d cyc=%0d expected slot=%0d step=%0d cyc=0",
                                 sl, cur_step, cis, e.slot, e.step);
                    end else if (bit_o[sl] !== e.b) begin
                        n_fail = n_fail + 1;
                        $display("FAIL %s: step %0d bit=%b expected %b", e.tag, e.step, bit_o[sl], e.b);
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests = n_tests + 1;
            n_fail  = n_fail + 1;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        din   = 1'b0;
        phase = 4'b0000;
        repeat (5) @(negedge clk);
        n_tests = n_tests + 1;
        if (bit_o !== 4'b0000 || valid_o !== 4'b0000) begin
            n_fail = n_fail + 1;
            $display("FAIL R1: in reset bit=%b valid=%b expected 0000 0000", bit_o, valid_o);
        end
        rst_n = 1'b1;
        @(negedge clk);
        n_tests = n_tests + 1;
        if (bit_o !== 4'b0000 || valid_o !== 4'b0000) begin
            n_fail = n_fail + 1;
            $display("FAIL R1: after reset bit=%b valid=%b expected 0000 0000", bit_o, valid_o);
        end

        run_step(20, 10, "R5");   // first sample: no reference yet
        run_step(20, 12, "R2");   // 60% duty
        run_step(20, 8,  "R3");   // 40% duty
        run_step(20, 10, "R4");   // exactly half
        run_step(20, 11, "R2");
        run_step(20, 9,  "R3");
        run_step(70, 35, "R2");   // long period becomes next reference
        run_step(40, 34, "R8");   // ref saturated at 64: 68 > 64
        run_step(40, 20, "R4");
        run_step(130, 130, "R9"); // high time beyond counter range
        run_step(20, 5,  "R8");   // ref 130 saturates to 64
        run_step(24, 13, "R10");  // slot reused after large counts
        run_step(24, 11, "R3");
        run_step(24, 12, "R4");
        run_step(24, 13, "R2");
        run_step(24, 12, "R10");
        run_step(24, 12, "R10");
        run_step(24, 12, "R10");

        phase = 4'b0000;
        din   = 1'b0;
        repeat (10) @(negedge clk);

        n_tests = n_tests + 1;
        if (sb_q.size() != 0) begin
            n_fail = n_fail + 1;
            $display("FAIL R5: %0d strobes missing, expected 0", sb_q.size());
        end
        n_tests = n_tests + 1;
        if (hold_err != 0) begin
            n_fail = n_fail + 1;
            $display("FAIL R7: %0d output changes without strobe, expected 0", hold_err);
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule